// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It does this by reading a two-level translation table held in ordinary memory. A requester presents the virtual address together with two flags: whether the access is a write and whether it comes from user mode. The walker then fetches the first-level entry through a word-wide memory port. The root base input gives the page that holds the first-level table. If that entry maps a 4 MB region, the walk stops there. If not, the walker fetches the second-level entry from the frame that the first entry names. The reply carries either the physical address with the permissions merged over the levels, or a fault.

When the permission check succeeds, the walker writes back any entry used in the walk whose referenced flag is still clear. It also writes back the final entry of a write access when that entry's modified flag is still clear. Each write-back is an ordinary word write on the same memory port. Only one translation is in flight at a time. Both the request side and the result side use valid/ready handshakes. Memory reads complete through a response strobe. Memory writes complete when the port accepts them.

Top module: `ptw_walker`

## Requirements
- R1: The first read goes to {root_base[31:12], vaddr[31:22], 2'b00}. For a small page, the second read goes to {first_entry[31:12], vaddr[21:12], 2'b00}.
- R2: For a small page the result address is {second_entry[31:12], vaddr[11:0]}, and res_large is 0.
- R3: A first-level entry with bit 0 (present) and bit 7 (large) both set ends the walk after one read. The result address is then {first_entry[31:22], vaddr[21:0]}, and res_large is 1.
- R4: An entry with bit 0 clear at either level gives res_fault=1 with res_fault_prot=0. No memory write is issued for that translation.
- R5: A user access needs bit 2 (user) set in every entry used. A user write also needs bit 1 (writable) set in every entry used. Supervisor accesses pass regardless of either bit. A failed check gives res_fault=1 with res_fault_prot=1 and no memory write. On success, res_attr_user and res_attr_rw are the AND of bit 2 and of bit 1 over the entries used.
- R6: On a fault, res_fault_write and res_fault_user repeat the write and user flags of the request that faulted.
- R7: After a successful check, any used entry whose bit 5 (referenced) is clear is written back with bit 5 set. An entry that is already marked is never written.
- R8: On a successful write, a final entry whose bit 6 (modified) is clear is written with bits 5 and 6 set. A read never sets bit 6. When both levels are written, the first-level entry is written before the second.
- R9: A write-back keeps every other bit of the entry as it was read, including bits 11..9. Those three bits have no effect on the result.
- R10: req_ready is high only while no translation is in flight. A result stays valid and unchanged until res_ready is taken.
- R11: A memory request that is not yet accepted keeps its address, write flag and data unchanged.
- R12: After reset, req_ready=1, res_valid=0 and mem_req_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_base | input | 32 | Physical base of the first-level table; bits 31..12 used, sampled with the request |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access |
| req_user | input | 1 | 1 for a user-mode access |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 for a word write, 0 for a word read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_fault | output | 1 | Translation faulted |
| res_fault_prot | output | 1 | Fault kind: 1 protection, 0 not present |
| res_fault_write | output | 1 | Write flag of the faulting access |
| res_fault_user | output | 1 | User flag of the faulting access |
| res_paddr | output | 32 | Physical address |
| res_attr_rw | output | 1 | Merged writable permission |
| res_attr_user | output | 1 | Merged user permission |
| res_large | output | 1 | Translation came from a 4 MB entry |

## Verification
The second-level response decides two things in the same cycle. It settles the merged protection verdict, and it also settles whether the first-level referenced flag, which is still pending, must be written. When the verdict is a fault, that pending first-level write must be dropped. Random trials provoke this by pairing first-level entries whose referenced flag is clear with second-level entries that deny user or write access. A bench model judges each trial from the entry values alone. It predicts the fault code and the exact list of write addresses and data, so a trial that faulted and still wrote memory is reported.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned OFF_W   = 12;
    localparam int unsigned IDX_W   = 10;
    localparam int unsigned BIG_OFF = OFF_W + IDX_W;

    localparam int unsigned B_PRES  = 0;
    localparam int unsigned B_WR    = 1;
    localparam int unsigned B_USR   = 2;
    localparam int unsigned B_REF   = 5;
    localparam int unsigned B_MOD   = 6;
    localparam int unsigned B_BIG   = 7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD1, ST_WT1, ST_RD2, ST_WT2, ST_WB1, ST_WB2, ST_DONE
    } walk_state_t;

    typedef struct packed {
        logic hit;
        logic prot;
        logic wr;
        logic usr;
    } fault_t;

    function automatic logic [WORD_W-1:0] slot_addr(
        input logic [WORD_W-1:0] base, input logic [IDX_W-1:0] idx);
        return {base[WORD_W-1:OFF_W], idx, 2'b00};
    endfunction
endpackage

// File: rtl/ptw_check.sv
module ptw_check
    import ptw_pkg::*;
(
    input  logic [WORD_W-1:0] entry,
    input  logic              par_wr,
    input  logic              par_usr,
    input  logic              is_final,
    input  logic              acc_write,
    input  logic              acc_user,
    output logic              present,
    output logic              perm_ok,
    output logic              eff_wr,
    output logic              eff_usr,
    output logic              need_wb,
    output logic [WORD_W-1:0] upd_entry
);
    logic set_mod;

    always_comb begin
        present   = entry[B_PRES];
        eff_wr    = par_wr & entry[B_WR];
        eff_usr   = par_usr & entry[B_USR];
        perm_ok   = (!acc_user || eff_usr) && (!(acc_user && acc_write) || eff_wr);
        set_mod   = is_final & acc_write;
        need_wb   = !entry[B_REF] || (set_mod && !entry[B_MOD]);
        upd_entry = entry;
        upd_entry[B_REF] = 1'b1;
        if (set_mod) upd_entry[B_MOD] = 1'b1;
    end
endmodule

// File: rtl/ptw_port.sv
module ptw_port
    import ptw_pkg::*;
(
    input  walk_state_t       state,
    input  logic [WORD_W-1:0] root_q,
    input  logic [WORD_W-1:0] va_q,
    input  logic [WORD_W-1:0] e1_q,
    input  logic [WORD_W-1:0] e1_upd_q,
    input  logic [WORD_W-1:0] e2_upd_q,
    output logic              mem_req_valid,
    output logic              mem_req_we,
    output logic [WORD_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata
);
    logic [WORD_W-1:0] dir_addr, tbl_addr;

    assign dir_addr = slot_addr(root_q, va_q[WORD_W-1 -: IDX_W]);
    assign tbl_addr = slot_addr(e1_q, va_q[OFF_W +: IDX_W]);

    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = dir_addr;
        mem_req_wdata = '0;
        unique case (state)
            ST_RD1: mem_req_valid = 1'b1;
            ST_RD2: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = tbl_addr;
            end
            ST_WB1: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_wdata = e1_upd_q;
            end
            ST_WB2: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = tbl_addr;
                mem_req_wdata = e2_upd_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] root_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [WORD_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [WORD_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic              res_fault,
    output logic              res_fault_prot,
    output logic              res_fault_write,
    output logic              res_fault_user,
    output logic [WORD_W-1:0] res_paddr,
    output logic              res_attr_rw,
    output logic              res_attr_user,
    output logic              res_large
);
    walk_state_t       state;
    logic [WORD_W-1:0] root_q, va_q, e1_q, e1_upd_q, e2_upd_q, paddr_q;
    logic              wr_q, usr_q, wb1_q, wb2_q, large_q, rw_at_q, usr_at_q;
    fault_t            flt_q;

    logic              second;
    logic              c_present, c_ok, c_wr, c_usr, c_wb;
    logic [WORD_W-1:0] c_upd;

    assign second = (state == ST_WT2);

    ptw_check u_check (
        .entry     (mem_rsp_data),
        .par_wr    (second ? e1_q[B_WR]  : 1'b1),
        .par_usr   (second ? e1_q[B_USR] : 1'b1),
        .is_final  (second | mem_rsp_data[B_BIG]),
        .acc_write (wr_q),
        .acc_user  (usr_q),
        .present   (c_present),
        .perm_ok   (c_ok),
        .eff_wr    (c_wr),
        .eff_usr   (c_usr),
        .need_wb   (c_wb),
        .upd_entry (c_upd)
    );

    ptw_port u_port (
        .state         (state),
        .root_q        (root_q),
        .va_q          (va_q),
        .e1_q          (e1_q),
        .e1_upd_q      (e1_upd_q),
        .e2_upd_q      (e2_upd_q),
        .mem_req_valid (mem_req_valid),
        .mem_req_we    (mem_req_we),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            root_q   <= '0;
            va_q     <= '0;
            e1_q     <= '0;
            e1_upd_q <= '0;
            e2_upd_q <= '0;
            paddr_q  <= '0;
            wr_q     <= 1'b0;
            usr_q    <= 1'b0;
            wb1_q    <= 1'b0;
            wb2_q    <= 1'b0;
            large_q  <= 1'b0;
            rw_at_q  <= 1'b0;
            usr_at_q <= 1'b0;
            flt_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    root_q  <= root_base;
                    va_q    <= req_vaddr;
                    wr_q    <= req_write;
                    usr_q   <= req_user;
                    flt_q   <= '0;
                    large_q <= 1'b0;
                    wb1_q   <= 1'b0;
                    wb2_q   <= 1'b0;
                    state   <= ST_RD1;
                end
                ST_RD1: if (mem_req_ready) state <= ST_WT1;
                ST_WT1: if (mem_rsp_valid) begin
                    e1_q     <= mem_rsp_data;
                    e1_upd_q <= c_upd;
                    if (!c_present) begin
                        flt_q <= '{hit: 1'b1, prot: 1'b0, wr: wr_q, usr: usr_q};
                        state <= ST_DONE;
                    end else if (mem_rsp_data[B_BIG]) begin
                        large_q <= 1'b1;
                        if (!c_ok) begin
                            flt_q <= '{hit: 1'b1, prot: 1'b1, wr: wr_q, usr: usr_q};
                            state <= ST_DONE;
                        end else begin
                            paddr_q  <= {mem_rsp_data[WORD_W-1:BIG_OFF], va_q[BIG_OFF-1:0]};
                            rw_at_q  <= c_wr;
                            usr_at_q <= c_usr;
                            state    <= c_wb ? ST_WB1 : ST_DONE;
                        end
                    end else begin
                        wb1_q <= c_wb;
                        state <= ST_RD2;
                    end
                end
                ST_RD2: if (mem_req_ready) state <= ST_WT2;
                ST_WT2: if (mem_rsp_valid) begin
                    e2_upd_q <= c_upd;
                    if (!c_present) begin
                        flt_q <= '{hit: 1'b1, prot: 1'b0, wr: wr_q, usr: usr_q};
                        state <= ST_DONE;
                    end else if (!c_ok) begin
                        flt_q <= '{hit: 1'b1, prot: 1'b1, wr: wr_q, usr: usr_q};
                        state <= ST_DONE;
                    end else begin
                        paddr_q  <= {mem_rsp_data[WORD_W-1:OFF_W], va_q[OFF_W-1:0]};
                        rw_at_q  <= c_wr;
                        usr_at_q <= c_usr;
                        wb2_q    <= c_wb;
                        state    <= wb1_q ? ST_WB1 : (c_wb ? ST_WB2 : ST_DONE);
                    end
                end
                ST_WB1: if (mem_req_ready) state <= wb2_q ? ST_WB2 : ST_DONE;
                ST_WB2: if (mem_req_ready) state <= ST_DONE;
                ST_DONE: if (res_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready       = (state == ST_IDLE);
    assign res_valid       = (state == ST_DONE);
    assign res_fault       = flt_q.hit;
    assign res_fault_prot  = flt_q.prot;
    assign res_fault_write = flt_q.wr;
    assign res_fault_user  = flt_q.usr;
    assign res_paddr       = paddr_q;
    assign res_attr_rw     = rw_at_q;
    assign res_attr_user   = usr_at_q;
    assign res_large       = large_q;

    // R10
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid || mem_req_valid) |-> !req_ready);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_paddr) && $stable(res_fault)
                                       && $stable(res_fault_prot)));

    // R11
    memreq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
                                               && $stable(mem_req_we) && $stable(mem_req_wdata)));

    // R7
    wb_marks_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_we) |-> (mem_req_wdata[B_REF] && mem_req_wdata[B_PRES]));

    // R5
    user_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_fault && usr_q) |-> res_attr_user);

    // R4
    no_write_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_we) |-> !flt_q.hit);
endmodule

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ROOT = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] root_base;
    logic        req_valid, req_ready, req_write, req_user;
    logic [31:0] req_vaddr;
    logic        mem_req_valid, mem_req_ready, mem_req_we;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        res_valid, res_ready, res_fault, res_fault_prot, res_fault_write, res_fault_user;
    logic [31:0] res_paddr;
    logic        res_attr_rw, res_attr_user, res_large;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker u0 (.*);

    int nchk = 0, nerr = 0;
    bit finished = 0;
    logic [31:0] mem [logic [31:0]];
    int rcnt, wcnt;
    logic [31:0] raddr [4];
    logic [31:0] wa [4];
    logic [31:0] wd [4];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory responder: decisions at negedge, handshake at the posedge between
    initial begin
        bit acc;
        logic acc_we;
        logic [31:0] acc_a, acc_d;
        acc = 0; acc_we = 0; acc_a = 0; acc_d = 0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            if (acc) begin
                if (acc_we) begin
                    mem[acc_a] = acc_d;
                    if (wcnt < 4) begin wa[wcnt] = acc_a; wd[wcnt] = acc_d; end
                    wcnt++;
                end else begin
                    mem_rsp_valid = 1;
                    mem_rsp_data  = mem.exists(acc_a) ? mem[acc_a] : 32'h0;
                    if (rcnt < 4) raddr[rcnt] = acc_a;
                    rcnt++;
                end
            end
            mem_req_ready = ($urandom % 4) != 0;
            acc    = !rst && mem_req_valid && mem_req_ready;
            acc_we = mem_req_we;
            acc_a  = mem_req_addr;
            acc_d  = mem_req_wdata;
        end
    end

    task automatic run(input logic [31:0] e1, input logic [31:0] e2, input logic [31:0] va,
                       input logic wr, input logic us, input string name);
        logic [31:0] a1, a2, p, u1, u2;
        logic big, fault, prot, erw, eus, w1, w2;
        int nrd, nwr, k;
        logic [31:0] held;
        a1 = {ROOT[31:12], va[31:22], 2'b00};
        a2 = {e1[31:12], va[21:12], 2'b00};
        mem.delete();
        mem[a1] = e1;
        mem[a2] = e2;
        rcnt = 0; wcnt = 0;
        // expected model
        big = e1[0] && e1[7];
        fault = 0; prot = 0; p = 0; erw = 0; eus = 0; w1 = 0; w2 = 0;
        u1 = e1 | 32'h20; u2 = e2 | 32'h20;
        if (!e1[0]) begin fault = 1; nrd = 1; end
        else if (big) begin
            nrd = 1; erw = e1[1]; eus = e1[2];
            if ((us && !eus) || (us && wr && !erw)) begin fault = 1; prot = 1; end
            else begin
                p = {e1[31:22], va[21:0]};
                if (wr) u1 = u1 | 32'h40;
                w1 = !e1[5] || (wr && !e1[6]);
            end
        end else begin
            nrd = 2;
            if (!e2[0]) fault = 1;
            else begin
                erw = e1[1] & e2[1]; eus = e1[2] & e2[2];
                if ((us && !eus) || (us && wr && !erw)) begin fault = 1; prot = 1; end
                else begin
                    p = {e2[31:12], va[11:0]};
                    if (wr) u2 = u2 | 32'h40;
                    w1 = !e1[5];
                    w2 = !e2[5] || (wr && !e2[6]);
                end
            end
        end
        nwr = int'(w1) + int'(w2);

        @(negedge clk);
        root_base = ROOT; req_vaddr = va; req_write = wr; req_user = us; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk({"R10 busy ", name}, {31'd0, req_ready}, 32'd0);
        k = 0;
        while (!res_valid && k < 2000) begin @(negedge clk); k++; end
        held = res_paddr;
        repeat ($urandom % 3) begin
            @(negedge clk);
            if (res_valid !== 1'b1 || res_paddr !== held) begin
                nchk++; nerr++;
                $display("FAIL R10 hold %s actual=%h expected=%h", name, res_paddr, held);
            end
        end
        chk({"R4/R5 fault ", name}, {31'd0, res_fault}, {31'd0, fault});
        if (fault) begin
            chk({"R4/R5 kind ", name}, {31'd0, res_fault_prot}, {31'd0, prot});
            chk({"R6 flags ", name}, {30'd0, res_fault_write, res_fault_user}, {30'd0, wr, us});
        end else begin
            chk({"R2/R3 paddr ", name}, res_paddr, p);
            chk({"R3 large ", name}, {31'd0, res_large}, {31'd0, big});
            chk({"R5 attrs ", name}, {30'd0, res_attr_rw, res_attr_user}, {30'd0, erw, eus});
        end
        chk({"R1/R3 reads ", name}, rcnt, nrd);
        chk({"R1 addr1 ", name}, raddr[0], a1);
        if (nrd == 2 && rcnt >= 2) chk({"R1 addr2 ", name}, raddr[1], a2);
        chk({"R4/R7/R8 writes ", name}, wcnt, nwr);
        if (wcnt == nwr) begin
            if (w1) begin
                chk({"R7/R9 wb1 addr ", name}, wa[0], a1);
                chk({"R8/R9 wb1 data ", name}, wd[0], u1);
            end
            if (w2) begin
                chk({"R8 wb2 addr ", name}, wa[nwr-1], a2);
                chk({"R8/R9 wb2 data ", name}, wd[nwr-1], u2);
            end
        end
        res_ready = 1;
        @(negedge clk);
        res_ready = 0;
        chk({"R10 release ", name}, {30'd0, res_valid, req_ready}, 32'd1);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        rst = 1; req_valid = 0; req_write = 0; req_user = 0; req_vaddr = 0;
        root_base = ROOT; res_ready = 0;
        repeat (3) @(negedge clk);
        // R12
        chk("R12 reset", {29'd0, req_ready, res_valid, mem_req_valid}, 32'd4);
        rst = 0;
        // directed corners
        run(32'h0020_3007, 32'h0123_4007, 32'h1234_5678, 1, 1, "small write A/D clear");
        run(32'h0020_3067, 32'h0123_4067, 32'h1234_5678, 1, 1, "small marked no wb");
        run(32'h0AC0_0087, 32'h0, 32'h0035_6ABC, 1, 0, "large write R3");
        run(32'h0AC0_00E7, 32'h0, 32'h0035_6ABC, 0, 1, "large marked R3");
        run(32'h0020_3006, 32'h0123_4007, 32'h0000_1000, 0, 0, "L1 absent R4");
        run(32'h0020_3007, 32'h0123_4006, 32'h0000_1000, 1, 1, "L2 absent R4");
        run(32'h0020_3003, 32'h0123_4007, 32'h8000_0000, 0, 1, "user denied L1 R5");
        run(32'h0020_3007, 32'h0123_4005, 32'h8000_0000, 1, 1, "user write RO R5");
        run(32'h0020_3001, 32'h0123_4001, 32'h8000_0000, 1, 0, "sup write RO R5");
        run(32'h0020_3E07, 32'h0123_4E07, 32'hFFFF_FFFF, 0, 1, "bits 11..9 R9");
        run(32'h0020_3007, 32'h0123_4027, 32'h0040_0000, 0, 0, "L1 ref only R7");
        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [31:0] e1, e2;
            e1 = {12'h002, 8'($urandom), 12'($urandom)};
            e2 = $urandom;
            e1[0] = ($urandom % 8) != 0;
            e1[7] = ($urandom % 3) == 0;
            e2[0] = ($urandom % 8) != 0;
            run(e1, e2, $urandom, 1'($urandom), 1'($urandom), "random");
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule